// File: doc/BRIEF.md
# Multi-Device ADC Readout Controller

This block is a host-side sequencer for a group of 16-bit serial converters. The converters share one convert strobe, one serial clock and one data return line. Each converter also has its own select line, which is the converter's data-input pin used as an active-low chip select. A single start request launches a conversion on every device at once. The controller holds the strobe high while it waits out the longest conversion time the devices can take. It then reads the devices one after another over the shared line, within the same strobe-high window.

Every select is held high when the strobe rises, and stays high for the whole conversion window. The devices therefore run without any busy indication. After the window, the controller lowers one select at a time, which puts that device's most significant bit on the line. It then issues sixteen serial clock pulses. The controller samples each bit on a rising edge, and the device moves to its next bit on the falling edge that follows. Each finished word is presented with its device index and a one-cycle valid pulse. A done pulse closes the sequence and drops the strobe.

Top module: `adc_chain_reader`

## Requirements
- R1: While reset is held, and when idle after reset, the convert strobe is low, the serial clock is low, every select is high (the select bus reads all ones), and busy, word valid and done are low.
- R2: A start request sampled while idle causes the convert strobe and busy to be high after the next clock edge, with every select high at that point.
- R3: After the strobe rises, every select stays high for exactly CONV_CYC system clocks. The first select goes low at the end of that window.
- R4: Devices are read in ascending index order, starting from index 0. At most one select is low at any time, and exactly one select is low at every serial clock rising edge.
- R5: The serial clock is low whenever a select falls. Each read produces exactly WORD_W rising edges and WORD_W falling edges, and every high phase lasts SCLK_DIV/2 system clocks.
- R6: Each word is assembled most significant bit first. Its top bit is the line value present after the select fell, and each later bit is the value sampled at the next serial clock rising edge.
- R7: For each device, word valid pulses for exactly one cycle, at the moment that device's select returns high. The pulse carries the assembled word and that device's index (0 to N_DEV-1).
- R8: The convert strobe stays high through every read and every word valid pulse. In the cycle after the last word valid pulse, done pulses for one cycle, and the strobe and busy are both low in that cycle.
- R9: A start request seen while busy, or during the done cycle, is ignored. No second strobe rise follows, and the strobe stays low until a new request arrives while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to run one conversion and readout sequence |
| sdo_i | input | 1 | Shared serial data line from the converters |
| cnv_o | output | 1 | Convert strobe shared by all devices |
| sel_n_o | output | N_DEV | Per-device active-low select, bit d for device d |
| sclk_o | output | 1 | Shared serial clock, idles low |
| busy_o | output | 1 | High from the strobe rise until the done cycle |
| word_o | output | WORD_W | Last assembled result word |
| word_idx_o | output | max(1, clog2(N_DEV)) | Device index of word_o |
| word_vld_o | output | 1 | One-cycle pulse marking a new result |
| done_o | output | 1 | One-cycle pulse after the last device is read |

## Verification
The hardest cases to reach from the ports are the two ways a start request can be ignored: a request in the middle of a sequence, and a request in the exact cycle when done is high, just before the controller returns to idle. The directed bench watches done at every falling clock edge and raises start in that same sample. It also pulses start during the conversion window. It then confirms that the strobe rises only once for the run. Three behavioural device models shift asymmetric words onto the shared line, so a wrong bit order, a wrong device order or a missing clock edge each produces a visibly different word.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_CONV  = 3'd1,
      ST_SETUP = 3'd2,
      ST_SHIFT = 3'd3,
      ST_NEXT  = 3'd4,
      ST_DONE  = 3'd5
   } rd_state_t;

   // bits needed to hold values 0..n-1, never less than one
   function automatic int unsigned width_of(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen
   import adc_rd_pkg::*;
#(
   parameter int unsigned SCLK_DIV = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic sclk_o,
   output logic rise_o,
   output logic per_end_o
);

   localparam int unsigned HALF = SCLK_DIV / 2;
   localparam int unsigned PH_W = width_of(SCLK_DIV);

   generate
      if (SCLK_DIV < 2 || (SCLK_DIV % 2) != 0) begin : g_bad_div
         $error("SCLK_DIV must be even and at least 2");
      end

      if (SCLK_DIV == 2) begin : g_toggle
         logic sclk_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sclk_q <= 1'b0;
            else if (!run_i) sclk_q <= 1'b0;
            else             sclk_q <= ~sclk_q;
         end

         assign sclk_o    = sclk_q;
         assign rise_o    = run_i & ~sclk_q;
         assign per_end_o = run_i & sclk_q;

         // R5
         sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !run_i |=> !sclk_q);
      end else begin : g_count
         logic [PH_W-1:0] ph_q;
         logic            sclk_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ph_q   <= '0;
               sclk_q <= 1'b0;
            end else if (!run_i) begin
               ph_q   <= '0;
               sclk_q <= 1'b0;
            end else begin
               ph_q <= (ph_q == PH_W'(SCLK_DIV - 1)) ? '0 : ph_q + PH_W'(1);
               if (ph_q == '0)                 sclk_q <= 1'b1;
               else if (ph_q == PH_W'(HALF))   sclk_q <= 1'b0;
            end
         end

         assign sclk_o    = sclk_q;
         assign rise_o    = run_i && (ph_q == '0);
         assign per_end_o = run_i && (ph_q == PH_W'(SCLK_DIV - 1));

         // R5
         sclk_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sclk_q) |=> sclk_q);
         // R5
         sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !run_i |=> !sclk_q);
      end
   endgenerate

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
   import adc_rd_pkg::*;
#(
   parameter int unsigned WORD_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              rise_i,
   input  logic              sdo_i,
   output logic [WORD_W-1:0] word_o,
   output logic              full_o
);

   localparam int unsigned CNT_W = width_of(WORD_W + 1);

   logic [WORD_W-1:0] shreg_q;
   logic [CNT_W-1:0]  nbits_q;

   generate
      if (WORD_W < 2) begin : g_bad_w
         $error("WORD_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         nbits_q <= '0;
      end else if (clear_i) begin
         nbits_q <= '0;
      end else if (rise_i && nbits_q != CNT_W'(WORD_W)) begin
         shreg_q <= {shreg_q[WORD_W-2:0], sdo_i};
         nbits_q <= nbits_q + CNT_W'(1);
      end
   end

   assign word_o = shreg_q;
   assign full_o = (nbits_q == CNT_W'(WORD_W));

   // R5
   no_extra_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_i |-> (nbits_q != CNT_W'(WORD_W)));

endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
   import adc_rd_pkg::*;
#(
   parameter int unsigned N_DEV    = 2,
   parameter int unsigned CONV_CYC = 100,
   localparam int unsigned IDX_W   = width_of(N_DEV)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             per_end_i,
   input  logic             full_i,
   output logic             run_o,
   output logic             clear_o,
   output logic             cnv_o,
   output logic [N_DEV-1:0] sel_n_o,
   output logic             busy_o,
   output logic             vld_o,
   output logic             done_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam int unsigned TMR_W = width_of(CONV_CYC);
   localparam logic [IDX_W-1:0] LAST_DEV = IDX_W'(N_DEV - 1);

   rd_state_t        state_q, st_nxt;
   logic [IDX_W-1:0] dev_q, dev_nxt;
   logic [TMR_W-1:0] tmr_q;
   logic             cnv_q, busy_q, vld_q, done_q;
   logic [N_DEV-1:0] sel_n_q;
   logic             sel_active_nxt;

   generate
      if (N_DEV < 1) begin : g_bad_n
         $error("N_DEV must be at least 1");
      end
      if (CONV_CYC < 1) begin : g_bad_conv
         $error("CONV_CYC must be at least 1");
      end
   endgenerate

   always_comb begin
      st_nxt  = state_q;
      dev_nxt = dev_q;
      unique case (state_q)
         ST_IDLE:  if (start_i) st_nxt = ST_CONV;
         ST_CONV:  if (tmr_q == '0) begin
                      st_nxt  = ST_SETUP;
                      dev_nxt = '0;
                   end
         ST_SETUP: st_nxt = ST_SHIFT;
         ST_SHIFT: if (per_end_i && full_i) st_nxt = ST_NEXT;
         ST_NEXT:  if (dev_q == LAST_DEV) begin
                      st_nxt = ST_DONE;
                   end else begin
                      st_nxt  = ST_SETUP;
                      dev_nxt = dev_q + IDX_W'(1);
                   end
         ST_DONE:  st_nxt = ST_IDLE;
         default:  st_nxt = ST_IDLE;
      endcase
   end

   assign sel_active_nxt = (st_nxt == ST_SETUP) || (st_nxt == ST_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dev_q   <= '0;
         tmr_q   <= '0;
         cnv_q   <= 1'b0;
         busy_q  <= 1'b0;
         vld_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= st_nxt;
         dev_q   <= dev_nxt;
         if (state_q == ST_IDLE && start_i)      tmr_q <= TMR_W'(CONV_CYC - 1);
         else if (state_q == ST_CONV && tmr_q != '0) tmr_q <= tmr_q - TMR_W'(1);
         cnv_q  <= (st_nxt != ST_IDLE) && (st_nxt != ST_DONE);
         busy_q <= (st_nxt != ST_IDLE) && (st_nxt != ST_DONE);
         vld_q  <= (st_nxt == ST_NEXT);
         done_q <= (st_nxt == ST_DONE);
      end
   end

   generate
      for (genvar d = 0; d < N_DEV; d++) begin : g_sel
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_n_q[d] <= 1'b1;
            else        sel_n_q[d] <= !(sel_active_nxt && dev_nxt == IDX_W'(d));
         end
      end
   endgenerate

   assign run_o   = (state_q == ST_SHIFT);
   assign clear_o = (state_q == ST_SETUP);
   assign cnv_o   = cnv_q;
   assign sel_n_o = sel_n_q;
   assign busy_o  = busy_q;
   assign vld_o   = vld_q;
   assign done_o  = done_q;
   assign idx_o   = dev_q;

   // R2
   cnv_rise_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cnv_q) |-> (&sel_n_q));
   // R3
   conv_sel_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CONV) |-> (&sel_n_q));
   // R4
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sel_n_q));
   // R8
   cnv_cover_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&sel_n_q) |-> cnv_q);
   // R7
   vld_sel_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> ((&sel_n_q) && cnv_q));
   // R8
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!cnv_q && !busy_q));
   // R9
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q || done_q) |=> !$rose(cnv_q));

endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader
   import adc_rd_pkg::*;
#(
   parameter int unsigned N_DEV    = 2,
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned CONV_CYC = 100,
   parameter int unsigned SCLK_DIV = 4
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic                       sdo_i,
   output logic                       cnv_o,
   output logic [N_DEV-1:0]           sel_n_o,
   output logic                       sclk_o,
   output logic                       busy_o,
   output logic [WORD_W-1:0]          word_o,
   output logic [width_of(N_DEV)-1:0] word_idx_o,
   output logic                       word_vld_o,
   output logic                       done_o
);

   logic run_w, clear_w, rise_w, per_end_w, full_w;

   adc_rd_seq #(
      .N_DEV    (N_DEV),
      .CONV_CYC (CONV_CYC)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .per_end_i (per_end_w),
      .full_i    (full_w),
      .run_o     (run_w),
      .clear_o   (clear_w),
      .cnv_o     (cnv_o),
      .sel_n_o   (sel_n_o),
      .busy_o    (busy_o),
      .vld_o     (word_vld_o),
      .done_o    (done_o),
      .idx_o     (word_idx_o)
   );

   adc_rd_sclk_gen #(
      .SCLK_DIV (SCLK_DIV)
   ) i_sclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_w),
      .sclk_o    (sclk_o),
      .rise_o    (rise_w),
      .per_end_o (per_end_w)
   );

   adc_rd_capture #(
      .WORD_W (WORD_W)
   ) i_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear_w),
      .rise_i  (rise_w),
      .sdo_i   (sdo_i),
      .word_o  (word_o),
      .full_o  (full_w)
   );

   // R5
   sclk_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_o |-> !(&sel_n_o));
   // R6
   word_full_at_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |-> full_w);

endmodule

// File: tb/test_adc_chain_reader.sv
`timescale 1ns/1ps
module test_adc_chain_reader;

   localparam int N    = 3;
   localparam int W    = 16;
   localparam int CONV = 20;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic sdo;
   logic cnv, sclk, busy, vld, done;
   logic [N-1:0] sel_n;
   logic [W-1:0] word;
   logic [1:0]   idx;

   always #2.5 clk = ~clk;

   adc_chain_reader #(
      .N_DEV (N), .WORD_W (W), .CONV_CYC (CONV), .SCLK_DIV (DIV)
   ) i_adc_chain_reader (
      .clk (clk), .rst_n (rst_n), .start_i (start), .sdo_i (sdo),
      .cnv_o (cnv), .sel_n_o (sel_n), .sclk_o (sclk), .busy_o (busy),
      .word_o (word), .word_idx_o (idx), .word_vld_o (vld), .done_o (done)
   );

   int n_vec = 0;
   int n_bad = 0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- converter models ----------------
   logic [W-1:0] dev_word [N];
   int           bidx [N] = '{default: -1};
   logic [N-1:0] sel_prev = '1;

   always @(sel_n) begin
      for (int d = 0; d < N; d++)
         if (sel_prev[d] === 1'b1 && sel_n[d] === 1'b0) bidx[d] = W - 1;
      sel_prev = sel_n;
   end

   always @(negedge sclk) begin
      for (int d = 0; d < N; d++)
         if (sel_n[d] === 1'b0 && bidx[d] >= 0) bidx[d] = bidx[d] - 1;
   end

   always @* begin
      sdo = 1'b0;
      for (int d = 0; d < N; d++)
         if (sel_n[d] === 1'b0 && bidx[d] >= 0) sdo = dev_word[d][bidx[d]];
   end

   // ---------------- port monitor ----------------
   logic         p_cnv = 1'b0, p_sclk = 1'b0;
   logic [N-1:0] p_sel = '1;
   int conv_cnt = 0, conv_len = -1, hi_run = 0;
   bit seen_sel = 1'b0;
   int rises [N] = '{default: 0};
   int vld_n = 0, done_n = 0, cnv_rises = 0;
   logic [W-1:0] vld_word [8];
   logic [1:0]   vld_idx  [8];
   logic         vld_cnv  [8];

   always @(negedge clk) begin
      if (rst_n) begin
         if (cnv && !p_cnv) begin
            cnv_rises++;
            conv_cnt = 1;
            seen_sel = 1'b0;
         end else if (cnv && (&sel_n) && !seen_sel) begin
            conv_cnt++;
         end
         if (!(&sel_n) && !seen_sel) begin
            seen_sel = 1'b1;
            conv_len = conv_cnt;
         end
         for (int d = 0; d < N; d++) begin
            if (p_sel[d] && !sel_n[d]) begin
               chk("R5", "sclk low at select fall", {31'd0, sclk}, 32'd0);
               rises[d] = 0;
            end
            if (!p_sel[d] && sel_n[d])
               chk("R5", "rising edges per read", rises[d], W);
         end
         if (sclk && !p_sclk) begin
            chk("R4", "selects low at sclk rise", $countones(~sel_n), 1);
            for (int d = 0; d < N; d++) if (!sel_n[d]) rises[d]++;
            hi_run = 1;
         end else if (sclk) begin
            hi_run++;
         end
         if (!sclk && p_sclk) chk("R5", "sclk high phase", hi_run, HALF);
         if (vld && vld_n < 8) begin
            vld_word[vld_n] = word;
            vld_idx[vld_n]  = idx;
            vld_cnv[vld_n]  = cnv;
            vld_n++;
         end
         if (done) begin
            done_n++;
            chk("R8", "cnv at done", {31'd0, cnv}, 32'd0);
            chk("R8", "busy at done", {31'd0, busy}, 32'd0);
         end
      end
      p_cnv  = cnv;
      p_sclk = sclk;
      p_sel  = sel_n;
   end

   // ---------------- scenarios ----------------
   task automatic clear_mon();
      vld_n = 0;
      done_n = 0;
      cnv_rises = 0;
      conv_len = -1;
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1", "cnv in reset", {31'd0, cnv}, 32'd0);
      chk("R1", "selects in reset", {29'd0, sel_n}, {29'd0, 3'b111});
      chk("R1", "sclk in reset", {31'd0, sclk}, 32'd0);
      chk("R1", "busy/vld/done in reset", {29'd0, busy, vld, done}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "idle outputs", {26'd0, cnv, sclk, busy, vld, done, 1'b0},
          32'd0);
      chk("R1", "idle selects", {29'd0, sel_n}, {29'd0, 3'b111});
   endtask

   task automatic t_read(input string name, input logic [W-1:0] w0,
                         input logic [W-1:0] w1, input logic [W-1:0] w2,
                         input bit poke);
      int guard = 0;
      dev_word[0] = w0;
      dev_word[1] = w1;
      dev_word[2] = w2;
      clear_mon();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk("R2", {name, " cnv after start"}, {31'd0, cnv}, 32'd1);
      chk("R2", {name, " busy after start"}, {31'd0, busy}, 32'd1);
      chk("R2", {name, " selects at strobe rise"}, {29'd0, sel_n}, {29'd0, 3'b111});
      if (poke) begin
         repeat (5) @(negedge clk);
         start = 1'b1;        // R9: request during the conversion window
         @(negedge clk) start = 1'b0;
      end
      while (done !== 1'b1 && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      if (poke) start = 1'b1; // R9: request in the done cycle
      @(negedge clk) start = 1'b0;
      chk("R8", {name, " done reached"}, {31'd0, guard < 5000}, 32'd1);
      repeat (30) @(negedge clk);
      chk("R3", {name, " conversion window"}, conv_len, CONV);
      chk("R7", {name, " valid count"}, vld_n, N);
      for (int i = 0; i < N && i < vld_n; i++) begin
         chk("R7", {name, " device index"}, {30'd0, vld_idx[i]}, i);
         chk("R6", {name, " word"}, {16'd0, vld_word[i]}, {16'd0, dev_word[i]});
         chk("R8", {name, " cnv at valid"}, {31'd0, vld_cnv[i]}, 32'd1);
      end
      chk("R8", {name, " done pulses"}, done_n, 1);
      chk("R9", {name, " strobe rises"}, cnv_rises, 1);
      chk("R9", {name, " idle after run"}, {30'd0, cnv, busy}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_read("mixed",   16'hA5C3, 16'h1234, 16'hFFFE, 1'b0);
      t_read("extreme", 16'hFFFF, 16'h0000, 16'h8001, 1'b0);
      t_read("walk",    16'h0001, 16'h8000, 16'h5555, 1'b1);
      t_read("again",   16'h3C96, 16'hC0DE, 16'h7FFF, 1'b1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule